// File: doc/BRIEF.md
# Upstream Buffer Ring Channel Manager

This block moves one stream of words from logic inside the chip toward a host. Words are taken from a first-word-fall-through FIFO. They are placed into a ring of host-side buffers, one buffer after another. For every word the block issues one write request that carries the buffer index, the offset inside that buffer and the data. The number of buffers and the buffer length are both powers of two. Buffer index and offset are therefore plain fields of a running position.

The host never polls the block. All status leaves as 32-bit words pushed onto a message lane. That lane holds messages only and never stream data.

- When a buffer fills, the block pushes a release message that names the buffer and its word count. One cycle later it pulses an interrupt request.
- A partly filled buffer goes out only when the host asks for a flush.
- When the channel turns from fully empty to holding data, the block can push a one-off notice so that a poll-style waiter can wake up.
- A released buffer is written again only after the host hands its index back as free. While the next buffer in the ring is still held by the host, the block stops reading the FIFO.

Top module: `ups_chan_mgr`

## Requirements
- R1: Reset state and start position. After reset, `fifo_rd`, `wr_valid`, `msg_push` and `irq` are low. The first word written goes to buffer 0 at offset 0.
- R2: Enable gating. While `en` is low, the block asserts no FIFO read and issues no write request, whatever the FIFO holds.
- R3: Write requests. Each word popped (`fifo_rd` high at a clock edge) gives exactly one write request (`wr_valid`) in the next cycle, with the popped data. Offsets rise from 0 to BUF_WORDS-1 inside a buffer. Buffers are used in strict cyclic order 0, 1, ..., NBUF-1, 0.
- R4: Release message. Writing the last offset of a buffer pushes a release message in the same cycle as that last write request. The message word is: opcode in [31:28] (1 = release), channel number CHAN_ID in [27:20], buffer index in [19:12], and the count of valid words in [11:0]. A full buffer reports BUF_WORDS. Every message carries CHAN_ID, which is at least 1.
- R5: Interrupt. `irq` is high for exactly one cycle, in the cycle after each release message. It is never high at any other time, and a nonempty notice never raises it.
- R6: Flush of a partial buffer. A one-cycle `flush_req` while the current buffer holds k > 0 words pushes a release message for that buffer with count k. Filling then restarts at offset 0 of the next buffer in the ring.
- R7: Flush on an empty buffer. A flush request that arrives while the current buffer holds no word is held and produces no message. It is serviced when the next word arrives, releasing that buffer with count 1. A release never reports a count of zero.
- R8: Buffer ownership. A released buffer is not written again until the host pulses `free_we` with its index on `free_idx`. While the current buffer in the ring is not free, `fifo_rd` stays low and the FIFO keeps its contents.
- R9: Nonempty notice. The channel counts as empty when every released buffer has been freed and the current buffer holds no word. On the first word popped while the channel is empty, the block pushes one message with opcode 2, channel CHAN_ID, and zero in the index and count fields. No further notice comes until the channel has been empty again.
- R10: With parameter NONEMPTY_EN = 0, the block never pushes an opcode-2 message. Release messages are unchanged.
- R11: Coincident messages. If one popped word both ends the empty state and triggers a release (a held flush), the nonempty notice is pushed first and the release exactly one cycle later. FIFO reading pauses for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Allows reading the user FIFO |
| fifo_empty | input | 1 | User FIFO holds no word |
| fifo_data | input | DATA_W | Head word of the user FIFO (fall-through) |
| fifo_rd | output | 1 | Pops the head word at this clock edge |
| free_we | input | 1 | Host marks one buffer free |
| free_idx | input | log2(NBUF) | Index of the buffer being freed |
| flush_req | input | 1 | Host asks for the partial buffer to be sent |
| wr_valid | output | 1 | Write request valid |
| wr_buf | output | log2(NBUF) | Target buffer index |
| wr_off | output | log2(BUF_WORDS) | Word offset inside the buffer |
| wr_data | output | DATA_W | Word to write |
| msg_push | output | 1 | Pushes `msg_data` onto the message lane |
| msg_data | output | 32 | Message word |
| irq | output | 1 | One-cycle interrupt request after a release |

## Verification
The bench builds the block with a 16-bit word, a ring of four buffers of four words each, and channel number 3. With so small a ring, a full buffer, wraparound to buffer 0 and complete exhaustion of free buffers are all reached within a few dozen words. A second copy built with NONEMPTY_EN = 0 runs on the same stimulus, with its own FIFO read pointer. It shows that only the notice disappears, while release messages and their count stay the same. Host frees and flushes are placed so that an empty channel, a held flush and a coincident notice-plus-release all occur.

// File: rtl/ups_pkg.sv
package ups_pkg;

    localparam int MSG_W = 32;

    typedef enum logic [3:0] {
        OP_IDLE     = 4'd0,
        OP_RELEASE  = 4'd1,
        OP_NONEMPTY = 4'd2
    } msg_op_e;

    typedef struct packed {
        msg_op_e     op;
        logic [7:0]  chan;
        logic [7:0]  bidx;
        logic [11:0] cnt;
    } msg_t;

    typedef struct packed {
        logic        fire;
        logic [7:0]  bidx;
        logic [11:0] cnt;
    } rel_evt_t;

    function automatic msg_t mk_msg(msg_op_e op, logic [7:0] chan,
                                    logic [7:0] bidx, logic [11:0] cnt);
        msg_t m;
        m.op   = op;
        m.chan = chan;
        m.bidx = bidx;
        m.cnt  = cnt;
        return m;
    endfunction

endpackage

// File: rtl/ups_ring_ctrl.sv
module ups_ring_ctrl
    import ups_pkg::*;
#(
    parameter int NBUF      = 4,
    parameter int BUF_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        fifo_empty,
    input  logic                        stall,
    input  logic                        flush_req,
    input  logic                        free_we,
    input  logic [$clog2(NBUF)-1:0]     free_idx,
    output logic                        pop,
    output logic [$clog2(NBUF)-1:0]     cur_buf,
    output logic [$clog2(BUF_WORDS)-1:0] cur_off,
    output logic                        first_data,
    output rel_evt_t                    rel
);
    localparam int BIDX_W = $clog2(NBUF);
    localparam int OFF_W  = $clog2(BUF_WORDS);

    logic [NBUF-1:0]   owned_q, owned_d;
    logic [BIDX_W-1:0] buf_q;
    logic [OFF_W-1:0]  off_q;
    logic              flush_q;
    logic              has_data, at_last, flush_any, rel_now, chan_empty;

    assign has_data   = (off_q != '0);
    assign chan_empty = (owned_q == '0) && !has_data;
    assign at_last    = (off_q == OFF_W'(BUF_WORDS - 1));
    assign flush_any  = flush_q || flush_req;
    assign pop        = en && !fifo_empty && !owned_q[buf_q] && !stall;
    assign rel_now    = pop ? (at_last || flush_any) : (flush_any && has_data);
    assign first_data = pop && chan_empty;

    assign rel.fire = rel_now;
    assign rel.bidx = 8'(buf_q);
    assign rel.cnt  = 12'(off_q) + 12'(pop);

    assign cur_buf = buf_q;
    assign cur_off = off_q;

    always_comb begin
        owned_d = owned_q;
        if (free_we) owned_d[free_idx] = 1'b0;
        if (rel_now) owned_d[buf_q]    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned_q <= '0;
            buf_q   <= '0;
            off_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            owned_q <= owned_d;
            flush_q <= flush_any && !rel_now;
            if (rel_now) begin
                buf_q <= buf_q + BIDX_W'(1);
                off_q <= '0;
            end else if (pop) begin
                off_q <= off_q + OFF_W'(1);
            end
        end
    end

endmodule

// File: rtl/ups_msg_out.sv
module ups_msg_out
    import ups_pkg::*;
#(
    parameter int CHAN_ID     = 1,
    parameter int NONEMPTY_EN = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  rel_evt_t         rel,
    input  logic             first_data,
    output logic             stall,
    output logic             msg_push,
    output logic [MSG_W-1:0] msg_data,
    output logic             irq
);
    localparam logic NE_ON = (NONEMPTY_EN != 0);
    localparam logic [7:0] CH = 8'(CHAN_ID);

    msg_t        msg_q;
    logic        push_q, irq_q, hold_q;
    logic [7:0]  hold_bidx;
    logic [11:0] hold_cnt;
    logic        ne_fire;

    assign ne_fire = NE_ON && first_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q     <= '0;
            push_q    <= 1'b0;
            irq_q     <= 1'b0;
            hold_q    <= 1'b0;
            hold_bidx <= '0;
            hold_cnt  <= '0;
        end else begin
            irq_q <= push_q && (msg_q.op == OP_RELEASE);
            if (ne_fire) begin
                push_q    <= 1'b1;
                msg_q     <= mk_msg(OP_NONEMPTY, CH, 8'd0, 12'd0);
                hold_q    <= rel.fire;
                hold_bidx <= rel.bidx;
                hold_cnt  <= rel.cnt;
            end else if (hold_q) begin
                push_q <= 1'b1;
                msg_q  <= mk_msg(OP_RELEASE, CH, hold_bidx, hold_cnt);
                hold_q <= 1'b0;
            end else if (rel.fire) begin
                push_q <= 1'b1;
                msg_q  <= mk_msg(OP_RELEASE, CH, rel.bidx, rel.cnt);
            end else begin
                push_q <= 1'b0;
            end
        end
    end

    assign stall    = hold_q;
    assign msg_push = push_q;
    assign msg_data = msg_q;
    assign irq      = irq_q;

endmodule

// File: rtl/ups_chan_mgr.sv
module ups_chan_mgr
    import ups_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NBUF        = 4,
    parameter int BUF_WORDS   = 64,
    parameter int CHAN_ID     = 1,
    parameter int NONEMPTY_EN = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         fifo_empty,
    input  logic [DATA_W-1:0]            fifo_data,
    output logic                         fifo_rd,
    input  logic                         free_we,
    input  logic [$clog2(NBUF)-1:0]      free_idx,
    input  logic                         flush_req,
    output logic                         wr_valid,
    output logic [$clog2(NBUF)-1:0]      wr_buf,
    output logic [$clog2(BUF_WORDS)-1:0] wr_off,
    output logic [DATA_W-1:0]            wr_data,
    output logic                         msg_push,
    output logic [MSG_W-1:0]             msg_data,
    output logic                         irq
);
    localparam int BIDX_W = $clog2(NBUF);
    localparam int OFF_W  = $clog2(BUF_WORDS);

    generate
        if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32)
            $error("DATA_W must be 8, 16 or 32");
        if (NBUF < 2 || NBUF > 256 || (NBUF & (NBUF - 1)) != 0)
            $error("NBUF must be a power of two in 2..256");
        if (BUF_WORDS < 2 || BUF_WORDS > 2048 || (BUF_WORDS & (BUF_WORDS - 1)) != 0)
            $error("BUF_WORDS must be a power of two in 2..2048");
        if (CHAN_ID < 1 || CHAN_ID > 255)
            $error("CHAN_ID must be 1..255");
    endgenerate

    logic              pop, stall, first_data;
    logic [BIDX_W-1:0] cur_buf;
    logic [OFF_W-1:0]  cur_off;
    rel_evt_t          rel;

    ups_ring_ctrl #(.NBUF(NBUF), .BUF_WORDS(BUF_WORDS)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .fifo_empty (fifo_empty),
        .stall      (stall),
        .flush_req  (flush_req),
        .free_we    (free_we),
        .free_idx   (free_idx),
        .pop        (pop),
        .cur_buf    (cur_buf),
        .cur_off    (cur_off),
        .first_data (first_data),
        .rel        (rel)
    );

    ups_msg_out #(.CHAN_ID(CHAN_ID), .NONEMPTY_EN(NONEMPTY_EN)) u_msg (
        .clk        (clk),
        .rst        (rst),
        .rel        (rel),
        .first_data (first_data),
        .stall      (stall),
        .msg_push   (msg_push),
        .msg_data   (msg_data),
        .irq        (irq)
    );

    assign fifo_rd = pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_buf   <= '0;
            wr_off   <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= pop;
            if (pop) begin
                wr_buf  <= cur_buf;
                wr_off  <= cur_off;
                wr_data <= fifo_data;
            end
        end
    end

endmodule

// File: rtl/ups_chan_chk.sv
module ups_chan_chk #(
    parameter int BUF_WORDS   = 64,
    parameter int CHAN_ID     = 1,
    parameter int NONEMPTY_EN = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        fifo_empty,
    input logic        fifo_rd,
    input logic        wr_valid,
    input logic        msg_push,
    input logic [31:0] msg_data,
    input logic        irq
);
    logic is_rel;
    assign is_rel = msg_push && (msg_data[31:28] == 4'd1);

    assert_no_read_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        !en |-> !fifo_rd);

    assert_no_read_empty_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    assert_write_follows_pop_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> wr_valid);

    assert_release_count_R7: assert property (@(posedge clk) disable iff (rst)
        is_rel |-> (msg_data[11:0] != 12'd0 && msg_data[11:0] <= 12'(BUF_WORDS)));

    assert_chan_field_R4: assert property (@(posedge clk) disable iff (rst)
        msg_push |-> (msg_data[27:20] == 8'(CHAN_ID)));

    assert_irq_after_release_R5: assert property (@(posedge clk) disable iff (rst)
        is_rel |=> irq);

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(is_rel));

    assert_nonempty_gate_R10: assert property (@(posedge clk) disable iff (rst)
        msg_push |-> (NONEMPTY_EN != 0 || msg_data[31:28] != 4'd2));

endmodule

bind ups_chan_mgr ups_chan_chk #(
    .BUF_WORDS(BUF_WORDS), .CHAN_ID(CHAN_ID), .NONEMPTY_EN(NONEMPTY_EN)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .wr_valid(wr_valid), .msg_push(msg_push), .msg_data(msg_data), .irq(irq)
);

// File: tb/sim_ups_chan_mgr.sv
`timescale 1ns/1ps
module sim_ups_chan_mgr;
    localparam int DW = 16, NB = 4, BW = 4, CH = 3;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0, free_we = 1'b0, flush_req = 1'b0;
    logic [1:0] free_idx = '0;
    logic [DW-1:0] mem [0:255];
    logic [7:0] head = '0, head1 = '0, tail = '0;
    logic fifo_rd, wr_valid, msg_push, irq;
    logic fifo_rd1, wr_valid1, msg_push1, irq1;
    logic [1:0] wr_buf, wr_buf1, wr_off, wr_off1;
    logic [DW-1:0] wr_data, wr_data1;
    logic [31:0] msg_data, msg_data1;
    logic fifo_empty, fifo_empty1;

    assign fifo_empty  = (head == tail);
    assign fifo_empty1 = (head1 == tail);

    always #4 clk = ~clk;

    ups_chan_mgr #(.DATA_W(DW), .NBUF(NB), .BUF_WORDS(BW), .CHAN_ID(CH), .NONEMPTY_EN(1)) u0 (
        .clk(clk), .rst(rst), .en(en), .fifo_empty(fifo_empty), .fifo_data(mem[head]),
        .fifo_rd(fifo_rd), .free_we(free_we), .free_idx(free_idx), .flush_req(flush_req),
        .wr_valid(wr_valid), .wr_buf(wr_buf), .wr_off(wr_off), .wr_data(wr_data),
        .msg_push(msg_push), .msg_data(msg_data), .irq(irq));

    ups_chan_mgr #(.DATA_W(DW), .NBUF(NB), .BUF_WORDS(BW), .CHAN_ID(CH), .NONEMPTY_EN(0)) u1 (
        .clk(clk), .rst(rst), .en(en), .fifo_empty(fifo_empty1), .fifo_data(mem[head1]),
        .fifo_rd(fifo_rd1), .free_we(free_we), .free_idx(free_idx), .flush_req(flush_req),
        .wr_valid(wr_valid1), .wr_buf(wr_buf1), .wr_off(wr_off1), .wr_data(wr_data1),
        .msg_push(msg_push1), .msg_data(msg_data1), .irq(irq1));

    int checks = 0, errors = 0;
    int cyc_n = 0, irq_bad = 0, ne1_bad = 0, rel0 = 0, rel1 = 0;
    int nv = 0, ew = 0, wr_rd = 0, msg_rd = 0;
    logic prev_rel = 1'b0;
    logic [19:0] wr_log [$];
    logic [31:0] msg_log [$];
    int msg_cyc [$];

    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (!rst) begin
            if (fifo_rd)  head  <= head + 8'd1;
            if (fifo_rd1) head1 <= head1 + 8'd1;
            if (wr_valid) wr_log.push_back({wr_buf, wr_off, wr_data});
            if (msg_push) begin
                msg_log.push_back(msg_data);
                msg_cyc.push_back(cyc_n);
                if (msg_data[31:28] == 4'd1) rel0 <= rel0 + 1;
            end
            if (irq !== prev_rel) irq_bad <= irq_bad + 1;
            prev_rel <= msg_push && msg_data[31:28] == 4'd1;
            if (msg_push1 && msg_data1[31:28] == 4'd2) ne1_bad <= ne1_bad + 1;
            if (msg_push1 && msg_data1[31:28] == 4'd1) rel1 <= rel1 + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            mem[tail] = 16'hA000 + 16'(nv);
            tail = tail + 8'd1;
            nv++;
        end
    endtask

    task automatic pulse_flush();
        flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
    endtask

    task automatic pulse_free(input int idx);
        free_idx = 2'(idx); free_we = 1'b1; @(negedge clk); free_we = 1'b0;
    endtask

    task automatic exp_wr(input int b, input int o, input string req);
        logic [19:0] e;
        e = {2'(b), 2'(o), 16'hA000 + 16'(ew)};
        ew++;
        if (wr_rd < wr_log.size()) begin
            check(wr_log[wr_rd] == e, req, "write request", wr_log[wr_rd], e);
            wr_rd++;
        end else check(1'b0, req, "missing write request", -1, e);
    endtask

    task automatic exp_msg(input int op, input int b, input int c, input string req);
        logic [31:0] e;
        e = {4'(op), 8'(CH), 8'(b), 12'(c)};
        if (msg_rd < msg_log.size()) begin
            check(msg_log[msg_rd] == e, req, "message", msg_log[msg_rd], e);
            msg_rd++;
        end else check(1'b0, req, "missing message", -1, e);
    endtask

    task automatic exp_quiet(input string req);
        check(wr_log.size() == wr_rd, req, "extra write requests", wr_log.size(), wr_rd);
        check(msg_log.size() == msg_rd, req, "extra messages", msg_log.size(), msg_rd);
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
        check(!fifo_rd && !wr_valid && !msg_push && !irq, "R1", "outputs after reset",
              {fifo_rd, wr_valid, msg_push, irq}, 0);
    endtask

    // R2
    task automatic t_disabled();
        push(2); cyc(10);
        check(head == 8'd0, "R2", "FIFO read while disabled", head, 0);
        exp_quiet("R2");
    endtask

    // R1, R3, R9
    task automatic t_fill();
        en = 1'b1; cyc(8);
        exp_msg(2, 0, 0, "R9");
        exp_wr(0, 0, "R1");
        exp_wr(0, 1, "R3");
        exp_quiet("R3");
    endtask

    // R4, R3, R9
    task automatic t_full();
        push(2); cyc(8);
        exp_wr(0, 2, "R3");
        exp_wr(0, 3, "R3");
        exp_msg(1, 0, BW, "R4");
        exp_quiet("R9");
    endtask

    // R6
    task automatic t_flush();
        push(1); cyc(6);
        pulse_flush(); cyc(6);
        exp_wr(1, 0, "R6");
        exp_msg(1, 1, 1, "R6");
        exp_quiet("R6");
    endtask

    // R7
    task automatic t_flush_empty();
        pulse_flush(); cyc(10);
        exp_quiet("R7");
        push(1); cyc(8);
        exp_wr(2, 0, "R6");
        exp_msg(1, 2, 1, "R7");
        exp_quiet("R7");
    endtask

    // R8, R9
    task automatic t_ring_full();
        push(4); cyc(10);
        for (int o = 0; o < BW; o++) exp_wr(3, o, "R3");
        exp_msg(1, 3, BW, "R4");
        push(2); cyc(10);
        check(tail - head == 8'd2, "R8", "FIFO words left while ring held", tail - head, 2);
        exp_quiet("R8");
        pulse_free(0); cyc(8);
        exp_wr(0, 0, "R8");
        exp_wr(0, 1, "R8");
        pulse_free(1); pulse_free(2); pulse_free(3);
        pulse_flush(); cyc(6);
        exp_msg(1, 0, 2, "R6");
        pulse_free(0); cyc(2);
        push(1); cyc(8);
        exp_msg(2, 0, 0, "R9");
        exp_wr(1, 0, "R8");
        exp_quiet("R9");
    endtask

    // R11
    task automatic t_both();
        int base;
        pulse_flush(); cyc(6);
        exp_msg(1, 1, 1, "R6");
        pulse_free(1); cyc(2);
        pulse_flush(); cyc(4);
        exp_quiet("R7");
        base = msg_rd;
        push(1); cyc(8);
        exp_msg(2, 0, 0, "R11");
        exp_msg(1, 2, 1, "R11");
        if (msg_cyc.size() >= base + 2)
            check(msg_cyc[base + 1] - msg_cyc[base] == 1, "R11", "gap between messages",
                  msg_cyc[base + 1] - msg_cyc[base], 1);
        exp_wr(2, 0, "R11");
        exp_quiet("R11");
    endtask

    // R5, R10
    task automatic t_totals();
        cyc(4);
        check(irq_bad == 0, "R5", "irq cycles not matching a release", irq_bad, 0);
        check(rel0 == 7, "R5", "release count", rel0, 7);
        check(ne1_bad == 0, "R10", "nonempty notices with notices disabled", ne1_bad, 0);
        check(rel1 == 7, "R10", "release count with notices disabled", rel1, 7);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_disabled();
        t_fill();
        t_full();
        t_flush();
        t_flush_empty();
        t_ring_full();
        t_both();
        t_totals();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule